// File: doc/BRIEF.md
# Power-Stage Fault Supervisor

This block is the digital fault manager that sits between a half-bridge power stage's comparator flags and its control outputs. It receives seven digitized condition flags (supply undervoltage, charge-pump undervoltage, overcurrent, open load, current-regulation trip, thermal shutdown and thermal warning) and a set of configuration bits held by a register interface. For every source it decides whether the active-low fault pin asserts, whether the bridge goes high-impedance and whether the control logic is held in reset. It also keeps per-source status bits and handles recovery: latched until cleared, released automatically, or re-enabled after a timed retry.

Fault states are registered. A flag seen at a rising clock edge shows up on the outputs right after that edge. The reporting-enable bits for current-regulation trip and thermal warning act combinationally on the fault pin and on the summary bit. A clear-fault pulse or a low sleep input releases the latched conditions. The retry interval is the parameter `RETRY_CYCLES`.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, fault_n is 1, bridge_hiz is 0, logic_reset is 0 and status is all zero.
- R2: A high uv_flag at an edge drives fault_n low and bridge_hiz, logic_reset and status[0] high after that edge. It also clears every latched fault and any retry in progress. All four release one edge after the flag drops.
- R3: With cpuv_disable=0, cpuv_flag makes status[1] high, fault_n low and bridge_hiz high, and this follows the flag automatically. With cpuv_disable=1 the flag has no effect on any output.
- R4: With oc_mode=00, overcurrent latches status[2], fault_n low and bridge_hiz high until a clear or a sleep releases it.
- R5: With oc_mode=01, overcurrent holds status[2], fault_n low and bridge_hiz high for RETRY_CYCLES cycles. The flag is then re-sampled: if it is still high a new interval starts, otherwise the bridge is released.
- R6: With oc_mode=10, status[2] and the fault pin follow the flag one edge later while bridge_hiz stays 0. With oc_mode=11, overcurrent changes no output.
- R7: When ol_passive_en or ol_active_en is 1, ol_flag latches status[3] and fault_n low without bridge_hiz. When both enables are 0, ol_flag has no effect.
- R8: itrip_flag sets status[4] one edge later and never sets bridge_hiz. It pulls fault_n low only while itrip_report=1.
- R9: With tsd_auto=0, tsd_flag latches status[5], fault_n low and bridge_hiz high until cleared. With tsd_auto=1 these follow the flag and release by themselves.
- R10: otw_flag always sets status[6] and never sets bridge_hiz. It pulls fault_n low and sets status[7] only while otw_report=1. The warning clears once the flag drops.
- R11: A clear_fault pulse releases only those latched faults whose flag is low at that edge; a flag high at the same edge keeps its latch. A low sleep_n releases all latches and any retry regardless of the flags.
- R12: status[7] is always the inverse of fault_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | 1 | Supply undervoltage comparator |
| cpuv_flag | input | 1 | Charge-pump undervoltage comparator |
| oc_flag | input | 1 | Overcurrent comparator |
| ol_flag | input | 1 | Open-load detected |
| itrip_flag | input | 1 | Current-regulation trip |
| tsd_flag | input | 1 | Thermal shutdown comparator |
| otw_flag | input | 1 | Thermal warning comparator |
| cpuv_disable | input | 1 | Ignore charge-pump undervoltage |
| oc_mode | input | 2 | 00 latch, 01 retry, 10 report only, 11 ignore |
| ol_passive_en | input | 1 | Passive open-load enable |
| ol_active_en | input | 1 | Active open-load enable |
| itrip_report | input | 1 | Report current trip on fault pin |
| tsd_auto | input | 1 | 1 auto-recover thermal shutdown, 0 latch |
| otw_report | input | 1 | Report thermal warning on fault pin |
| clear_fault | input | 1 | Clear-fault pulse |
| sleep_n | input | 1 | Active-low sleep, releases latches |
| fault_n | output | 1 | Active-low combined fault pin |
| bridge_hiz | output | 1 | Bridge outputs high-impedance |
| logic_reset | output | 1 | Hold control logic in reset |
| status | output | 8 | 0 uv, 1 cpuv, 2 oc, 3 ol, 4 itrip, 5 tsd, 6 otw, 7 summary |

## Verification
Two events can land in the same edge. A clear_fault pulse can coincide with a latched source's flag still being high, and the retry interval can expire while the overcurrent flag is still high. The bench drives clear_fault together with a re-risen overcurrent and thermal-shutdown flag, and holds overcurrent across more than one retry interval. A behavioural model judges every cycle: a clear must lose to a live flag, and an expiring retry must start a new interval with no gap on bridge_hiz.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    OC_LATCH  = 2'b00,
    OC_RETRY  = 2'b01,
    OC_REPORT = 2'b10,
    OC_IGNORE = 2'b11
  } oc_mode_e;

  localparam int ST_UV    = 0;
  localparam int ST_CPUV  = 1;
  localparam int ST_OC    = 2;
  localparam int ST_OL    = 3;
  localparam int ST_ITRIP = 4;
  localparam int ST_TSD   = 5;
  localparam int ST_OTW   = 6;
  localparam int ST_SUM   = 7;
  localparam int ST_W     = 8;

  localparam int LAT_OC  = 0;
  localparam int LAT_OL  = 1;
  localparam int LAT_TSD = 2;
  localparam int N_LAT   = 3;
endpackage

// File: rtl/fsup_latch_cell.sv
module fsup_latch_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic arm,
  input  logic flag,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= 1'b0;
    else if (kill)        q <= 1'b0;
    else if (arm)         q <= 1'b1;
    else if (clr && !flag) q <= 1'b0;
  end
endmodule

// File: rtl/fsup_retry_timer.sv
module fsup_retry_timer #(
  parameter int CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic start,
  input  logic flag,
  output logic busy
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (kill) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      busy <= start;
      cnt  <= '0;
    end else if (cnt == LAST) begin
      busy <= flag;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int RETRY_CYCLES = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uv_flag,
  input  logic            cpuv_flag,
  input  logic            oc_flag,
  input  logic            ol_flag,
  input  logic            itrip_flag,
  input  logic            tsd_flag,
  input  logic            otw_flag,
  input  logic            cpuv_disable,
  input  logic [1:0]      oc_mode,
  input  logic            ol_passive_en,
  input  logic            ol_active_en,
  input  logic            itrip_report,
  input  logic            tsd_auto,
  input  logic            otw_report,
  input  logic            clear_fault,
  input  logic            sleep_n,
  output logic            fault_n,
  output logic            bridge_hiz,
  output logic            logic_reset,
  output logic [ST_W-1:0] status
);
  oc_mode_e mode;
  assign mode = oc_mode_e'(oc_mode);

  logic kill;
  assign kill = uv_flag || !sleep_n;

  // live (auto-recovering) conditions
  logic uv_q, cpuv_q, oc_rep_q, itrip_q, tsd_live_q, otw_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q       <= 1'b0;
      cpuv_q     <= 1'b0;
      oc_rep_q   <= 1'b0;
      itrip_q    <= 1'b0;
      tsd_live_q <= 1'b0;
      otw_q      <= 1'b0;
    end else begin
      uv_q       <= uv_flag;
      cpuv_q     <= cpuv_flag && !cpuv_disable;
      oc_rep_q   <= oc_flag && (mode == OC_REPORT);
      itrip_q    <= itrip_flag;
      tsd_live_q <= tsd_flag && tsd_auto;
      otw_q      <= otw_flag;
    end
  end

  // latched conditions
  logic [N_LAT-1:0] arm_v, flag_v, lat_q;
  always_comb begin
    arm_v          = '0;
    flag_v         = '0;
    arm_v[LAT_OC]  = oc_flag && (mode == OC_LATCH);
    flag_v[LAT_OC] = oc_flag;
    arm_v[LAT_OL]  = ol_flag && (ol_passive_en || ol_active_en);
    flag_v[LAT_OL] = ol_flag;
    arm_v[LAT_TSD] = tsd_flag && !tsd_auto;
    flag_v[LAT_TSD] = tsd_flag;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_LAT; gi++) begin : g_lat
      fsup_latch_cell u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .kill (kill),
        .arm  (arm_v[gi]),
        .flag (flag_v[gi]),
        .clr  (clear_fault),
        .q    (lat_q[gi])
      );
    end
  endgenerate

  logic retry_busy;
  fsup_retry_timer #(.CYCLES(RETRY_CYCLES)) u_retry (
    .clk  (clk),
    .rst_n(rst_n),
    .kill (kill),
    .start(oc_flag && (mode == OC_RETRY)),
    .flag (oc_flag),
    .busy (retry_busy)
  );

  logic oc_any, tsd_any, fault_any;
  assign oc_any  = lat_q[LAT_OC] || retry_busy || oc_rep_q;
  assign tsd_any = lat_q[LAT_TSD] || tsd_live_q;

  assign fault_any = uv_q || cpuv_q || oc_any || lat_q[LAT_OL] ||
                     (itrip_q && itrip_report) || tsd_any ||
                     (otw_q && otw_report);

  assign fault_n     = !fault_any;
  assign bridge_hiz  = uv_q || cpuv_q || lat_q[LAT_OC] || retry_busy || tsd_any;
  assign logic_reset = uv_q;

  always_comb begin
    status           = '0;
    status[ST_UV]    = uv_q;
    status[ST_CPUV]  = cpuv_q;
    status[ST_OC]    = oc_any;
    status[ST_OL]    = lat_q[LAT_OL];
    status[ST_ITRIP] = itrip_q;
    status[ST_TSD]   = tsd_any;
    status[ST_OTW]   = otw_q;
    status[ST_SUM]   = fault_any;
  end
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_flag,
  input logic       oc_flag,
  input logic [1:0] oc_mode,
  input logic       sleep_n,
  input logic       cpuv_disable,
  input logic       otw_flag,
  input logic       fault_n,
  input logic       bridge_hiz,
  input logic       logic_reset,
  input logic [7:0] status
);
  a_r2_uv_forces: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (bridge_hiz && logic_reset && !fault_n));

  a_r3_cpuv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cpuv_disable |=> !status[1]);

  a_r4_oc_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == 2'b00 && oc_flag && !uv_flag && sleep_n) |=> (status[2] && bridge_hiz));

  a_r10_otw_seen: assert property (@(posedge clk) disable iff (!rst_n)
    otw_flag |=> status[6]);

  a_r11_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !status[3]);

  a_r12_summary: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == !fault_n);
endmodule

bind fault_supervisor fsup_checker u_fsup_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .uv_flag     (uv_flag),
  .oc_flag     (oc_flag),
  .oc_mode     (oc_mode),
  .sleep_n     (sleep_n),
  .cpuv_disable(cpuv_disable),
  .otw_flag    (otw_flag),
  .fault_n     (fault_n),
  .bridge_hiz  (bridge_hiz),
  .logic_reset (logic_reset),
  .status      (status)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int RC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_flag = 0, cpuv_flag = 0, oc_flag = 0, ol_flag = 0, itrip_flag = 0;
  logic tsd_flag = 0, otw_flag = 0, cpuv_disable = 0;
  logic [1:0] oc_mode = 2'b00;
  logic ol_passive_en = 0, ol_active_en = 0, itrip_report = 0, tsd_auto = 0;
  logic otw_report = 0, clear_fault = 0, sleep_n = 1;
  logic fault_n, bridge_hiz, logic_reset;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  fault_supervisor #(.RETRY_CYCLES(RC)) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .cpuv_flag(cpuv_flag),
    .oc_flag(oc_flag), .ol_flag(ol_flag), .itrip_flag(itrip_flag),
    .tsd_flag(tsd_flag), .otw_flag(otw_flag), .cpuv_disable(cpuv_disable),
    .oc_mode(oc_mode), .ol_passive_en(ol_passive_en), .ol_active_en(ol_active_en),
    .itrip_report(itrip_report), .tsd_auto(tsd_auto), .otw_report(otw_report),
    .clear_fault(clear_fault), .sleep_n(sleep_n), .fault_n(fault_n),
    .bridge_hiz(bridge_hiz), .logic_reset(logic_reset), .status(status)
  );

  // behavioural reference state
  bit m_uv, m_cpuv, m_ocl, m_ocr, m_oc2, m_ol, m_it, m_tsdl, m_tsda, m_otw;
  int m_rem;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_uv, m_cpuv, m_ocl, m_ocr, m_oc2, m_ol, m_it, m_tsdl, m_tsda, m_otw} = '0;
      m_rem = 0;
    end else begin
      bit wipe;
      wipe = uv_flag || !sleep_n;
      m_uv = uv_flag;
      m_cpuv = cpuv_flag && !cpuv_disable;
      m_oc2 = oc_flag && oc_mode == 2'b10;
      m_it = itrip_flag;
      m_tsda = tsd_flag && tsd_auto;
      m_otw = otw_flag;
      if (wipe) m_ocl = 0;
      else if (oc_flag && oc_mode == 2'b00) m_ocl = 1;
      else if (clear_fault && !oc_flag) m_ocl = 0;
      if (wipe) m_ol = 0;
      else if (ol_flag && (ol_passive_en || ol_active_en)) m_ol = 1;
      else if (clear_fault && !ol_flag) m_ol = 0;
      if (wipe) m_tsdl = 0;
      else if (tsd_flag && !tsd_auto) m_tsdl = 1;
      else if (clear_fault && !tsd_flag) m_tsdl = 0;
      if (wipe) begin
        m_ocr = 0;
      end else if (!m_ocr) begin
        if (oc_flag && oc_mode == 2'b01) begin m_ocr = 1; m_rem = RC; end
      end else begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          if (oc_flag) m_rem = RC; else m_ocr = 0;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    begin
      bit e_any, e_hiz;
      logic [7:0] e_st;
      e_any = m_uv || m_cpuv || m_ocl || m_ocr || m_oc2 || m_ol ||
              (m_it && itrip_report) || m_tsdl || m_tsda || (m_otw && otw_report);
      e_hiz = m_uv || m_cpuv || m_ocl || m_ocr || m_tsdl || m_tsda;
      e_st = {e_any, m_otw, m_tsdl || m_tsda, m_it, m_ol, m_ocl || m_ocr || m_oc2, m_cpuv, m_uv};
      chk("fault_n", fault_n, !e_any);
      chk("bridge_hiz", bridge_hiz, e_hiz);
      chk("logic_reset", logic_reset, m_uv);
      chk("status", status, e_st);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clear_fault = 1; step(1); clear_fault = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    phase = "R1"; step(3); rst_n = 1; step(3);
    // R2: undervoltage wipes an open-load latch
    phase = "R2"; ol_passive_en = 1; ol_flag = 1; step(2); ol_flag = 0; step(2);
    uv_flag = 1; step(3); uv_flag = 0; step(3); ol_passive_en = 0;
    // R3
    phase = "R3"; cpuv_flag = 1; step(3); cpuv_flag = 0; step(2);
    cpuv_disable = 1; cpuv_flag = 1; step(3); cpuv_flag = 0; cpuv_disable = 0; step(2);
    // R4 and R11: clear while flag high, then with flag low
    phase = "R4"; oc_mode = 2'b00; oc_flag = 1; step(3);
    phase = "R11"; pulse_clear(); step(2); oc_flag = 0; step(2);
    phase = "R4"; pulse_clear(); step(2);
    // R5: retry, held across two intervals
    phase = "R5"; oc_mode = 2'b01; oc_flag = 1; step(RC + 6); oc_flag = 0; step(2 * RC + 4);
    oc_flag = 1; step(1); oc_flag = 0; step(RC + 4);
    // R6
    phase = "R6"; oc_mode = 2'b10; oc_flag = 1; step(3); oc_flag = 0; step(2);
    oc_mode = 2'b11; oc_flag = 1; step(3); oc_flag = 0; step(2); oc_mode = 2'b00;
    // R7
    phase = "R7"; ol_active_en = 1; ol_flag = 1; step(2); ol_flag = 0; step(3);
    pulse_clear(); step(2); ol_active_en = 0; ol_flag = 1; step(3); ol_flag = 0; step(2);
    // R8
    phase = "R8"; itrip_flag = 1; step(3); itrip_report = 1; step(3);
    itrip_flag = 0; step(2); itrip_report = 0;
    // R9
    phase = "R9"; tsd_flag = 1; step(3); tsd_flag = 0; step(3); pulse_clear(); step(2);
    tsd_auto = 1; tsd_flag = 1; step(3); tsd_flag = 0; step(3); tsd_auto = 0;
    // R10
    phase = "R10"; otw_flag = 1; step(3); otw_report = 1; step(3);
    otw_flag = 0; step(2); otw_report = 0;
    // R11: clear coinciding with re-risen flags, then sleep
    phase = "R11"; oc_flag = 1; tsd_flag = 1; step(2); oc_flag = 0; tsd_flag = 0; step(2);
    oc_flag = 1; tsd_flag = 1; clear_fault = 1; step(1); clear_fault = 0;
    oc_flag = 0; tsd_flag = 0; step(3);
    ol_passive_en = 1; ol_flag = 1; step(2); ol_flag = 0; step(1);
    sleep_n = 0; step(2); sleep_n = 1; step(3);
    phase = "R12"; otw_report = 1; otw_flag = 1; step(2); otw_flag = 0; step(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule